// File: doc/BRIEF.md
# Parity-Check-Count Timing Search Controller

This controller runs the coarse acquisition stage of a BPSK receiver whose frames carry an LDPC code. No pilot symbols are used. For every hypothesis of timing offset and frequency offset, the controller sends a request carrying that hypothesis. It then accepts the hard-decision code word that the resampler produces for it. It scores the word by counting how many rows of a fixed parity-check matrix come out with even parity. The hypothesis with the highest score wins.

A search is a series of passes, and each pass has eight candidates per axis. In joint mode, each pass scans the timing axis first and then the frequency axis. Each axis scan is centred on the best value found so far. After each pass the step is halved, so the window narrows around the peak. After the last pass the controller presents the chosen offset pair, its score and an all-checks-satisfied flag. A separate tracking stage takes this result and removes the residual error.

Top module: `pcc_search_ctrl`

## Requirements
- R1: While rst_n is low, req_valid, word_ready and res_valid are all 0. After release, req_valid rises within six clock cycles.
- R2: The score of a word is the number of rows r for which the XOR of word_data bits selected by row r of the matrix is 0. With the default matrix, bit 8+j is parity bit j and covers data bits j, (j+1) mod 8 and (j+3) mod 8. The reported count is the score of the chosen candidate.
- R3: Within one axis scan, candidate k (k = 0..7, issued in increasing k) sits at centre + (k-4)*step on the scanned axis.
- R4: Requests and words alternate strictly. After a request is accepted, word_ready rises. After a word is accepted, either the next request or the result is offered. req_valid and word_ready are never high together.
- R5: At the end of an axis scan, the centre of that axis moves to the best candidate. The step of both axes is the initial step shifted right by the pass number. There are three passes, and the result offsets are the final centres.
- R6: In joint mode, a pass scans timing with frequency held at its centre, then scans frequency with timing held at its new centre.
- R7: When two candidates in a scan have equal scores, the one issued earlier is kept.
- R8: res_valid, res_toff, res_foff, res_count and res_all_ok hold steady until res_ready is seen high.
- R9: res_all_ok is 1 exactly when res_count equals the number of matrix rows.
- R10: After the result is accepted, a new search begins at once from the initial centres and the initial step.
- R11: While req_valid is high and req_ready is low, req_valid and both request offsets hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | output | 1 | Candidate hypothesis offered |
| req_ready | input | 1 | Resampler takes the hypothesis |
| req_toff | output | W | Signed timing offset of the candidate |
| req_foff | output | W | Signed frequency offset of the candidate |
| word_valid | input | 1 | Hard-decision word present |
| word_ready | output | 1 | Controller waits for a word |
| word_data | input | N | Hard-decision code word |
| res_valid | output | 1 | Search result offered |
| res_ready | input | 1 | Tracking stage takes the result |
| res_toff | output | W | Chosen timing offset |
| res_foff | output | W | Chosen frequency offset |
| res_count | output | clog2(M+1) | Satisfied checks at the chosen offset |
| res_all_ok | output | 1 | Every check satisfied at the chosen offset |

## Verification
Two updates can land on the same edge. When the eighth word of a scan arrives, the controller scores it and may make it the new best. On that same edge it moves the axis centre that the next scan uses. The bench provokes this by placing the true timing offset exactly on the last candidate of the first window. It then judges every later request against a behavioural model that rebuilds the expected window from its own candidate scores. A second scenario forces equal scores in the finest window, which checks that the tie rule holds on those same closing edges.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RES  = 2'd3
  } pcc_state_e;

  // search axis selected by the axis flag
  localparam logic AX_TIME = 1'b0;
  localparam logic AX_FREQ = 1'b1;
endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pcc_check_eval.sv
module pcc_check_eval #(
  parameter int unsigned N  = 16,
  parameter int unsigned M  = 8,
  parameter logic [M*N-1:0] H = '0,
  parameter int unsigned CW = $clog2(M + 1)
) (
  input  logic [N-1:0]  word,
  output logic [CW-1:0] sat_cnt
);
  logic [M-1:0] row_ok;

  // one parity row per generate instance
  for (genvar r = 0; r < M; r++) begin : g_row
    assign row_ok[r] = ~(^(word & H[r*N +: N]));
  end

  always_comb begin
    sat_cnt = '0;
    for (int i = 0; i < M; i++) begin
      sat_cnt = sat_cnt + CW'(row_ok[i]);
    end
  end
endmodule

// File: rtl/pcc_cand_gen.sv
module pcc_cand_gen #(
  parameter int unsigned W     = 10,
  parameter int unsigned NCAND = 8,
  parameter int unsigned IDXW  = $clog2(NCAND)
) (
  input  logic signed [W-1:0] center,
  input  logic signed [W-1:0] step,
  input  logic [IDXW-1:0]     idx,
  output logic signed [W-1:0] cand
);
  localparam logic signed [W-1:0] HALF = W'(NCAND / 2);

  logic signed [W-1:0]   rel;
  logic signed [2*W-1:0] prod;

  always_comb begin
    rel  = $signed({{(W-IDXW){1'b0}}, idx}) - HALF;
    prod = rel * step;
    cand = center + $signed(prod[W-1:0]);
  end
endmodule

// File: rtl/pcc_best_track.sv
module pcc_best_track #(
  parameter int unsigned W  = 10,
  parameter int unsigned CW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               first,
  input  logic signed [W-1:0] cand_t,
  input  logic signed [W-1:0] cand_f,
  input  logic [CW-1:0]      cnt,
  output logic signed [W-1:0] best_t,
  output logic signed [W-1:0] best_f,
  output logic [CW-1:0]      best_cnt,
  output logic signed [W-1:0] nxt_t,
  output logic signed [W-1:0] nxt_f,
  output logic [CW-1:0]      nxt_cnt
);
  logic take;

  // strict greater-than keeps the earlier of two equal scores
  always_comb begin
    take    = first || (cnt > best_cnt);
    nxt_t   = take ? cand_t : best_t;
    nxt_f   = take ? cand_f : best_f;
    nxt_cnt = take ? cnt    : best_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_t   <= '0;
      best_f   <= '0;
      best_cnt <= '0;
    end else if (en) begin
      best_t   <= nxt_t;
      best_f   <= nxt_f;
      best_cnt <= nxt_cnt;
    end
  end
endmodule

// File: rtl/pcc_search_ctrl.sv
module pcc_search_ctrl
  import pcc_pkg::*;
#(
  parameter int unsigned N       = 16,
  parameter int unsigned M       = 8,
  parameter logic [M*N-1:0] H    = {16'h8085, 16'h40C2, 16'h2061, 16'h10B0,
                                    16'h0858, 16'h042C, 16'h0216, 16'h010B},
  parameter int unsigned W       = 10,
  parameter int unsigned NCAND   = 8,
  parameter int unsigned NPASS   = 3,
  parameter int          STEP_T0 = 16,
  parameter int          STEP_F0 = 16,
  parameter int          INIT_T  = 0,
  parameter int          INIT_F  = 0,
  parameter int unsigned MODE    = 2,   // 0 timing, 1 frequency, 2 joint
  parameter int unsigned CW      = $clog2(M + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                req_valid,
  input  logic                req_ready,
  output logic signed [W-1:0] req_toff,
  output logic signed [W-1:0] req_foff,
  input  logic                word_valid,
  output logic                word_ready,
  input  logic [N-1:0]        word_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic signed [W-1:0] res_toff,
  output logic signed [W-1:0] res_foff,
  output logic [CW-1:0]       res_count,
  output logic                res_all_ok
);
  localparam int unsigned IDXW = $clog2(NCAND);
  localparam int unsigned PW   = (NPASS > 1) ? $clog2(NPASS) : 1;
  localparam logic [IDXW-1:0] IDX_LAST  = IDXW'(NCAND - 1);
  localparam logic [PW-1:0]   PASS_LAST = PW'(NPASS - 1);
  localparam logic signed [W-1:0] ST_T0 = W'(STEP_T0);
  localparam logic signed [W-1:0] ST_F0 = W'(STEP_F0);
  localparam logic signed [W-1:0] C_T0  = W'(INIT_T);
  localparam logic signed [W-1:0] C_F0  = W'(INIT_F);
  localparam logic FIRST_AX = (MODE == 1) ? AX_FREQ : AX_TIME;

  logic rst_ni;

  pcc_state_e state_q, state_n;
  logic [IDXW-1:0]     idx_q, idx_n;
  logic [PW-1:0]       pass_q, pass_n;
  logic                ax_q, ax_n;
  logic signed [W-1:0] ctr_t_q, ctr_t_n, ctr_f_q, ctr_f_n;
  logic                ctl_en;

  logic signed [W-1:0] step_t, step_f, step_sel, ctr_sel, cand;
  logic [CW-1:0]       sat_cnt;
  logic                accept, ax_within, last_phase;
  logic signed [W-1:0] best_t, best_f, nxt_t, nxt_f;
  logic [CW-1:0]       best_cnt, nxt_cnt;

  pcc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  pcc_check_eval #(.N(N), .M(M), .H(H), .CW(CW)) u_eval (
    .word    (word_data),
    .sat_cnt (sat_cnt)
  );

  assign step_t   = ST_T0 >>> pass_q;
  assign step_f   = ST_F0 >>> pass_q;
  assign step_sel = (ax_q == AX_FREQ) ? step_f  : step_t;
  assign ctr_sel  = (ax_q == AX_FREQ) ? ctr_f_q : ctr_t_q;

  pcc_cand_gen #(.W(W), .NCAND(NCAND), .IDXW(IDXW)) u_cand (
    .center (ctr_sel),
    .step   (step_sel),
    .idx    (idx_q),
    .cand   (cand)
  );

  assign req_toff = (ax_q == AX_FREQ) ? ctr_t_q : cand;
  assign req_foff = (ax_q == AX_FREQ) ? cand    : ctr_f_q;

  assign accept = (state_q == ST_WAIT) && word_valid;

  pcc_best_track #(.W(W), .CW(CW)) u_best (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en       (accept),
    .first    (idx_q == '0),
    .cand_t   (req_toff),
    .cand_f   (req_foff),
    .cnt      (sat_cnt),
    .best_t   (best_t),
    .best_f   (best_f),
    .best_cnt (best_cnt),
    .nxt_t    (nxt_t),
    .nxt_f    (nxt_f),
    .nxt_cnt  (nxt_cnt)
  );

  // axis sequencing depends on the search mode
  if (MODE == 2) begin : g_joint
    assign ax_within = (ax_q == AX_TIME);
  end else begin : g_single
    assign ax_within = 1'b0;
  end

  assign last_phase = (pass_q == PASS_LAST) && !ax_within;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    pass_n  = pass_q;
    ax_n    = ax_q;
    ctr_t_n = ctr_t_q;
    ctr_f_n = ctr_f_q;
    unique case (state_q)
      ST_IDLE: state_n = ST_REQ;
      ST_REQ: begin
        if (req_ready) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (word_valid) begin
          state_n = ST_REQ;
          if (idx_q == IDX_LAST) begin
            idx_n = '0;
            if (ax_q == AX_FREQ) ctr_f_n = nxt_f;
            else                 ctr_t_n = nxt_t;
            if (last_phase) begin
              state_n = ST_RES;
            end else if (ax_within) begin
              ax_n = AX_FREQ;
            end else begin
              ax_n   = FIRST_AX;
              pass_n = pass_q + 1'b1;
            end
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      ST_RES: begin
        if (res_ready) begin
          state_n = ST_REQ;
          idx_n   = '0;
          pass_n  = '0;
          ax_n    = FIRST_AX;
          ctr_t_n = C_T0;
          ctr_f_n = C_F0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_n != state_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pass_q  <= '0;
      ax_q    <= FIRST_AX;
      ctr_t_q <= C_T0;
      ctr_f_q <= C_F0;
    end else if (ctl_en) begin
      state_q <= state_n;
      idx_q   <= idx_n;
      pass_q  <= pass_n;
      ax_q    <= ax_n;
      ctr_t_q <= ctr_t_n;
      ctr_f_q <= ctr_f_n;
    end
  end

  assign req_valid  = (state_q == ST_REQ);
  assign word_ready = (state_q == ST_WAIT);
  assign res_valid  = (state_q == ST_RES);
  assign res_toff   = ctr_t_q;
  assign res_foff   = ctr_f_q;
  assign res_count  = best_cnt;
  assign res_all_ok = (best_cnt == CW'(M));
endmodule

// File: rtl/pcc_search_chk.sv
module pcc_search_chk #(
  parameter int unsigned W  = 10,
  parameter int unsigned M  = 8,
  parameter int unsigned CW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic signed [W-1:0] req_toff,
  input logic signed [W-1:0] req_foff,
  input logic                word_valid,
  input logic                word_ready,
  input logic                res_valid,
  input logic                res_ready,
  input logic signed [W-1:0] res_toff,
  input logic signed [W-1:0] res_foff,
  input logic [CW-1:0]       res_count,
  input logic                res_all_ok
);
  a_r4_word_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_ready) |-> $past(req_valid && req_ready));

  a_r4_req_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past((word_ready && word_valid) || (res_valid && res_ready)
                               || (!word_ready && !res_valid)));

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_toff) && $stable(req_foff));

  a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_toff) && $stable(res_foff)
                                && $stable(res_count) && $stable(res_all_ok));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_count <= CW'(M));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_valid);
endmodule

bind pcc_search_ctrl pcc_search_chk #(.W(W), .M(M), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_toff   (req_toff),
  .req_foff   (req_foff),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_toff   (res_toff),
  .res_foff   (res_foff),
  .res_count  (res_count),
  .res_all_ok (res_all_ok)
);

// File: tb/pcc_search_ctrl_tb.sv
`timescale 1ns/1ps
module pcc_search_ctrl_tb;
  localparam int W = 10;
  localparam int N = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, word_valid, word_ready, res_valid, res_ready, res_all_ok;
  logic signed [W-1:0] req_toff, req_foff, res_toff, res_foff;
  logic [N-1:0] word_data;
  logic [CW-1:0] res_count;

  int checks = 0;
  int fails = 0;
  int stage = 0;       // 0 request expected, 1 word expected, 2 result expected
  bit mon_on = 1'b0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pcc_search_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_toff(req_toff), .req_foff(req_foff),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_toff(res_toff), .res_foff(res_foff),
    .res_count(res_count), .res_all_ok(res_all_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // R4 per-clock handshake model
  always @(negedge clk) begin
    if (mon_on) begin
      chk(req_valid == (stage == 0), "R4 req_valid", int'(req_valid), int'(stage == 0));
      chk(word_ready == (stage == 1), "R4 word_ready", int'(word_ready), int'(stage == 1));
      chk(res_valid == (stage == 2), "R8 res_valid", int'(res_valid), int'(stage == 2));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // codeword from the R2 row layout, with e parity bits flipped
  function automatic logic [15:0] mk_word(input logic [7:0] d, input int e);
    logic [7:0] p;
    logic [7:0] msk;
    for (int j = 0; j < 8; j++) p[j] = d[j] ^ d[(j + 1) % 8] ^ d[(j + 3) % 8];
    msk = 8'((16'h1 << e) - 1);
    return {p ^ msk, d};
  endfunction

  task automatic do_search(input int tt, input int tf, input int maxd,
                           output int rt, output int rf, output int rc);
    int ct, cf, step, bc, bt, bf, et, ef, e, cnt;
    ct = 0; cf = 0;
    for (int p = 0; p < 3; p++) begin
      for (int a = 0; a < 2; a++) begin
        step = 16 >> p;
        bc = -1; bt = 0; bf = 0;
        for (int k = 0; k < 8; k++) begin
          et = (a == 0) ? ct + (k - 4) * step : ct;
          ef = (a == 1) ? cf + (k - 4) * step : cf;
          while (!req_valid) @(negedge clk);
          chk(int'(req_toff) == et, "R11 toff pre-stall", int'(req_toff), et);
          repeat ($urandom_range(0, maxd)) @(negedge clk);
          chk(int'(req_toff) == et, (a == 0) ? "R3 timing cand" : "R6 timing held", int'(req_toff), et);
          chk(int'(req_foff) == ef, (a == 1) ? "R3 freq cand" : "R6 freq held", int'(req_foff), ef);
          req_ready = 1'b1;
          @(posedge clk); #1;
          req_ready = 1'b0;
          stage = 1;
          @(negedge clk);
          while (!word_ready) @(negedge clk);
          repeat ($urandom_range(0, maxd)) @(negedge clk);
          e = (iabs(et - tt) + iabs(ef - tf)) >> 3;
          if (e > 8) e = 8;
          cnt = 8 - e;
          word_data = mk_word(8'($urandom), e);
          word_valid = 1'b1;
          @(posedge clk); #1;
          word_valid = 1'b0;
          if (cnt > bc) begin bc = cnt; bt = et; bf = ef; end
          stage = (p == 2 && a == 1 && k == 7) ? 2 : 0;
        end
        if (a == 0) ct = bt; else cf = bf;
      end
    end
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    chk(int'(res_toff) == ct, "R8 toff pre-stall", int'(res_toff), ct);
    repeat ($urandom_range(0, maxd)) @(negedge clk);
    chk(int'(res_toff) == ct, "R5 result timing", int'(res_toff), ct);
    chk(int'(res_foff) == cf, "R5 result freq", int'(res_foff), cf);
    chk(int'(res_count) == bc, "R2 result count", int'(res_count), bc);
    chk(res_all_ok == (bc == 8), "R9 all_ok", int'(res_all_ok), int'(bc == 8));
    res_ready = 1'b1;
    @(posedge clk); #1;
    res_ready = 1'b0;
    stage = 0;
    @(negedge clk);
    chk(req_valid == 1'b1, "R10 restart valid", int'(req_valid), 1);
    chk(int'(req_toff) == -64 && int'(req_foff) == 0, "R10 restart centre", int'(req_toff), -64);
    rt = ct; rf = cf; rc = bc;
  endtask

  initial begin
    int rt, rf, rc;
    int waitc;
    rst_n = 1'b0; req_ready = 1'b0; word_valid = 1'b0; res_ready = 1'b0; word_data = '0;
    repeat (4) begin
      @(negedge clk);
      chk(!req_valid && !word_ready && !res_valid, "R1 reset outputs",
          int'({req_valid, word_ready, res_valid}), 0);
    end
    rst_n = 1'b1;
    waitc = 0;
    while (!req_valid && waitc < 6) begin @(negedge clk); waitc++; end
    chk(req_valid == 1'b1, "R1 first request", waitc, 6);
    stage = 0;
    mon_on = 1'b1;

    // aligned signal: equal scores in the finest timing window
    do_search(0, 0, 0, rt, rf, rc);
    chk(rt == -4, "R7 tie keeps earlier", rt, -4);
    chk(rc == 8, "R9 aligned count", rc, 8);
    // peak on the last candidate of the first window
    do_search(48, -40, 2, rt, rf, rc);
    // offsets beyond reach of the windows
    do_search(120, 110, 3, rt, rf, rc);
    // moderate offsets with long stalls
    do_search(-20, 13, 4, rt, rf, rc);

    mon_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule